// File: doc/BRIEF.md
# Serial Register Bridge

The bridge gives a host processor access to the 16-bit registers of a companion chip through a four-wire serial link. The host side is a plain memory-mapped port with a 16-bit byte address, separate read and write strobes and 32-bit data. Any host write that lands in a 4 KB slave window is turned into an address/data pair and queued in a small write FIFO. A serial engine empties that FIFO one frame at a time.

Reads are split into two steps. The host writes a slave register address to a command register, and the bridge raises a busy flag at once. When every queued write has gone out, the bridge runs a read frame. It then clears the flag and presents the returned value together with the slave address it belongs to, so software can check that the answer matches the question. A status register shows the FIFO fill level, the full and empty flags, and a sticky flag that records dropped writes.

Top module: `sreg_bridge`

## Requirements
- R1: After reset the read-result register (0x2C) reads 0x00000000, the status register (0x30) reads 0x00000400 (only the empty flag set), and the serial select and serial clock are both low.
- R2: A host write to any byte address from 0x8000 to 0x8FFF queues the pair {address bits 11:0, data bits 15:0}, and that pair is later written into the slave register with that 12-bit address.
- R3: A frame keeps select high for 29 serial clocks. It carries a direction bit (0 = write, 1 = read), then the 12-bit address, then 16 data bits, each field MSB first. The serial clock is the system clock divided by 4: two cycles low, then two cycles high. MOSI changes while the clock is low and both sides sample on the rising edge. When work is waiting, two frames are separated by exactly one system cycle with select low.
- R4: Writing offset 0x28 starts a read of the slave address held in data bits 11:0. Bit 31 of offset 0x2C reads 1 on the first host read after that command write.
- R5: When a read completes, bit 31 of 0x2C reads 0, bits 15:0 hold the 16 bits sampled from MISO, bits 27:16 hold the 12-bit slave address, and bits 30:28 are 0. Address bits above bit 11 in the command are discarded.
- R6: A read command written while bit 31 is still set is ignored; the read in progress keeps its address.
- R7: A read frame is not started until the write FIFO is empty, so a read returns the value of the last queued write to that address.
- R8: The status register 0x30 shows the full flag in bit 11, the empty flag in bit 10 and the FIFO fill count in bits 3:0.
- R9: The FIFO holds 8 entries. A window write that finds it full is dropped and sets the sticky bit 12 of 0x30. Bit 12 stays set until the host writes 0x30 with bit 12 set.
- R10: A window write that arrives in the same cycle that a full FIFO hands an entry to the serial engine is accepted and does not set the overflow bit.
- R11: Reads of undefined offsets, and reads inside the slave window, return 0. Writes to undefined offsets, and to addresses outside the window, change nothing and start no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 16 | Host byte address |
| host_rd | input | 1 | Host read strobe; data appears on host_rdata after the next edge |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| ser_clk | output | 1 | Serial clock, system clock divided by 4 |
| ser_sel | output | 1 | Frame select, active high |
| ser_mosi | output | 1 | Serial data toward the slave |
| ser_miso | input | 1 | Serial data from the slave |

## Verification
Two events can fall in the same cycle: a host window write, and the serial engine taking the oldest FIFO entry while the FIFO is full. The bench fills the FIFO behind a frame that is in progress and waits for select to fall. It then issues one more window write in the very next cycle, which is the cycle in which the next frame starts and pops an entry. The check is that the status still shows 8 entries with no overflow, and that the extra value later reaches the modelled slave register file. A write issued to the same full FIFO with no pop in that cycle is checked to be dropped and to set the sticky flag.

// File: rtl/sreg_pkg.sv
// Shared constants and types for the serial register bridge.
// Assumes a 16-bit host byte address and 16-bit slave registers.
package sreg_pkg;
    localparam int SADDR_W  = 12;
    localparam int SDATA_W  = 16;
    localparam int FRAME_W  = 1 + SADDR_W + SDATA_W;
    localparam int HADDR_W  = 16;
    localparam int HDATA_W  = 32;

    localparam logic [HADDR_W-1:0] OFS_RDCMD  = 16'h0028;
    localparam logic [HADDR_W-1:0] OFS_RDRES  = 16'h002C;
    localparam logic [HADDR_W-1:0] OFS_STAT   = 16'h0030;
    localparam logic [HADDR_W-1:0] WIN_BASE   = 16'h8000;
    localparam int                 WIN_BITS   = 12;

    localparam int BUSY_BIT  = 31;
    localparam int OVF_BIT   = 12;
    localparam int FULL_BIT  = 11;
    localparam int EMPTY_BIT = 10;

    typedef struct packed {
        logic [SADDR_W-1:0] addr;
        logic [SDATA_W-1:0] data;
    } wr_entry_t;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;
endpackage

// File: rtl/sreg_wfifo.sv
// Write queue for slave address/data pairs.
// A push is accepted when the queue is not full, or when a pop happens in
// the same cycle. A pop is honoured only while the queue holds data.
// Assumes DEPTH >= 2.
module sreg_wfifo #(
    parameter int DEPTH = 8,
    parameter int W     = 28
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       full,
    output logic                       empty,
    output logic                       accepted,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          pop_ok;

    // Flags and handshake qualifiers derived from the fill count
    always_comb begin
        full     = (cnt == CW'(DEPTH));
        empty    = (cnt == '0);
        accepted = push && (!full || pop);
        pop_ok   = pop && !empty;
        dout     = mem[rp];
        count    = cnt;
    end

    // Storage array written on accepted pushes
    always_ff @(posedge clk) begin
        if (accepted) mem[wp] <= din;
    end

    // Pointer and count bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (accepted) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (pop_ok)   rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
            if (accepted && !pop_ok)      cnt <= cnt + 1'b1;
            else if (!accepted && pop_ok) cnt <= cnt - 1'b1;
        end
    end

    // R9
    fifo_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (cnt == $past(cnt)));

    // R8
    fifo_fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/sreg_link.sv
// Serial frame engine. One frame is a direction bit, an address and a data
// word, sent MSB first. The serial clock is clk / CLK_DIV: low for the first
// half of each bit, high for the second half. MOSI moves while the clock is
// low, and MISO is captured as the clock rises during the data bits.
// Assumes CLK_DIV is even and >= 2, and that start is raised only while idle.
module sreg_link
    import sreg_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  dir_e               dir,
    input  logic [SADDR_W-1:0] addr,
    input  logic [SDATA_W-1:0] wdata,
    output logic               busy,
    output logic               done,
    output logic [SDATA_W-1:0] rdata,
    output logic               ser_clk,
    output logic               ser_sel,
    output logic               ser_mosi,
    input  logic               ser_miso
);
    localparam int HALF     = CLK_DIV / 2;
    localparam int PHW      = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int BCW      = $clog2(FRAME_W);
    localparam int DATA_POS = 1 + SADDR_W;

    logic               active;
    logic [PHW-1:0]     ph;
    logic [BCW-1:0]     bitn;
    logic [FRAME_W-1:0] shreg;
    logic [SDATA_W-1:0] rsh;

    // Pin drive derived from the frame state
    always_comb begin
        busy     = active;
        ser_sel  = active;
        ser_clk  = active && (ph >= PHW'(HALF));
        ser_mosi = active && shreg[FRAME_W-1];
        rdata    = rsh;
    end

    // Frame sequencing: phase counter, bit counter, shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            ph     <= '0;
            bitn   <= '0;
            shreg  <= '0;
            rsh    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    ph     <= '0;
                    bitn   <= '0;
                    shreg  <= {dir, addr, wdata};
                end
            end else begin
                ph <= (ph == PHW'(CLK_DIV-1)) ? '0 : ph + 1'b1;
                if (ph == PHW'(HALF-1) && bitn >= BCW'(DATA_POS))
                    rsh <= {rsh[SDATA_W-2:0], ser_miso};
                if (ph == PHW'(CLK_DIV-1)) begin
                    if (bitn == BCW'(FRAME_W-1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bitn  <= bitn + 1'b1;
                        shreg <= {shreg[FRAME_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // R3
    link_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);

    // R3
    link_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/sreg_bridge.sv
// Host-to-serial register bridge top. Decodes the host port, queues window
// writes, runs posted reads behind the queued writes, and shapes the
// read-result and status words.
// Assumes a single host access per cycle (rd and wr never both set).
module sreg_bridge
    import sreg_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int CLK_DIV    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [HDATA_W-1:0] host_wdata,
    output logic [HDATA_W-1:0] host_rdata,
    output logic               ser_clk,
    output logic               ser_sel,
    output logic               ser_mosi,
    input  logic               ser_miso
);
    localparam int CW = $clog2(FIFO_DEPTH+1);
    localparam int EW = $bits(wr_entry_t);

    logic               win_hit, win_wr, cmd_wr, stat_wr;
    wr_entry_t          push_ent, head_ent;
    logic               fifo_full, fifo_empty, fifo_acc, fifo_pop;
    logic [CW-1:0]      fifo_cnt;
    logic               link_busy, link_done, link_start;
    dir_e               link_dir;
    logic [SADDR_W-1:0] link_addr;
    logic [SDATA_W-1:0] link_wdata, link_rdata;
    logic               start_wr, start_rd;
    logic               rd_busy, rd_issued, ovf;
    logic [SADDR_W-1:0] rd_addr, rd_echo;
    logic [SDATA_W-1:0] rd_val;
    logic [HDATA_W-1:0] stat_word, res_word;

    // Host address decode
    always_comb begin
        win_hit  = (host_addr[HADDR_W-1:WIN_BITS] == WIN_BASE[HADDR_W-1:WIN_BITS]);
        win_wr   = host_wr && win_hit;
        cmd_wr   = host_wr && (host_addr == OFS_RDCMD);
        stat_wr  = host_wr && (host_addr == OFS_STAT);
        push_ent = '{addr: host_addr[SADDR_W-1:0], data: host_wdata[SDATA_W-1:0]};
    end

    sreg_wfifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (EW)
    ) u_wfifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (win_wr),
        .din      (push_ent),
        .pop      (fifo_pop),
        .dout     (head_ent),
        .full     (fifo_full),
        .empty    (fifo_empty),
        .accepted (fifo_acc),
        .count    (fifo_cnt)
    );

    // Frame scheduler: queued writes first, the posted read only once drained
    always_comb begin
        start_wr   = !link_busy && !fifo_empty;
        start_rd   = !link_busy && fifo_empty && rd_busy && !rd_issued;
        link_start = start_wr || start_rd;
        fifo_pop   = start_wr;
        link_dir   = start_wr ? DIR_WRITE : DIR_READ;
        link_addr  = start_wr ? head_ent.addr : rd_addr;
        link_wdata = start_wr ? head_ent.data : '0;
    end

    sreg_link #(
        .CLK_DIV (CLK_DIV)
    ) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (link_start),
        .dir      (link_dir),
        .addr     (link_addr),
        .wdata    (link_wdata),
        .busy     (link_busy),
        .done     (link_done),
        .rdata    (link_rdata),
        .ser_clk  (ser_clk),
        .ser_sel  (ser_sel),
        .ser_mosi (ser_mosi),
        .ser_miso (ser_miso)
    );

    // Posted-read tracking: command capture, issue mark, result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_busy   <= 1'b0;
            rd_issued <= 1'b0;
            rd_addr   <= '0;
            rd_echo   <= '0;
            rd_val    <= '0;
        end else begin
            if (cmd_wr && !rd_busy) begin
                rd_busy <= 1'b1;
                rd_addr <= host_wdata[SADDR_W-1:0];
            end
            if (start_rd) rd_issued <= 1'b1;
            if (link_done && rd_issued) begin
                rd_busy   <= 1'b0;
                rd_issued <= 1'b0;
                rd_val    <= link_rdata;
                rd_echo   <= rd_addr;
            end
        end
    end

    // Sticky overflow: set by a dropped window write, cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n)                              ovf <= 1'b0;
        else if (win_wr && !fifo_acc)            ovf <= 1'b1;
        else if (stat_wr && host_wdata[OVF_BIT]) ovf <= 1'b0;
    end

    // Status and read-result word assembly
    always_comb begin
        stat_word            = '0;
        stat_word[OVF_BIT]   = ovf;
        stat_word[FULL_BIT]  = fifo_full;
        stat_word[EMPTY_BIT] = fifo_empty;
        stat_word[CW-1:0]    = fifo_cnt;
        res_word = {rd_busy, {(HDATA_W-1-SADDR_W-SDATA_W){1'b0}}, rd_echo, rd_val};
    end

    // Registered host read mux
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            case (host_addr)
                OFS_RDCMD: host_rdata <= HDATA_W'(rd_addr);
                OFS_RDRES: host_rdata <= res_word;
                OFS_STAT:  host_rdata <= stat_word;
                default:   host_rdata <= '0;
            endcase
        end
    end

    // R7
    rd_after_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_start && link_dir == DIR_READ) |-> fifo_empty);

    // R4
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_busy) |-> $past(cmd_wr));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && cmd_wr) |=> $stable(rd_addr));

    // R9
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(win_wr && fifo_full && !fifo_pop));
endmodule

// File: tb/sreg_bridge_bench.sv
module sreg_bridge_bench;
    import sreg_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        ser_clk, ser_sel, ser_mosi;
    logic        ser_miso = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sreg_bridge u_sreg_bridge (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ser_clk(ser_clk), .ser_sel(ser_sel), .ser_mosi(ser_mosi), .ser_miso(ser_miso)
    );

    function automatic logic [15:0] init_val(int i);
        return 16'((i * 257) ^ 16'hC3A5);
    endfunction

    // Slave register file model (indexed by address bits 7:0)
    logic [15:0] smem [256];
    logic [28:0] sh;
    int          bc;
    logic        rdmode;
    logic [15:0] sout;
    int          wr_frames = 0;
    logic [11:0] last_waddr = '0;
    longint      t_prev = 0;
    longint      last_per = 0;

    initial for (int i = 0; i < 256; i++) smem[i] = init_val(i);

    always @(posedge ser_sel) begin
        bc = 0; sh = '0; rdmode = 1'b0;
    end
    always @(posedge ser_clk) begin
        if (bc > 0) last_per = $time - t_prev;
        t_prev = $time;
        sh = {sh[27:0], ser_mosi};
        bc++;
        if (bc == 13 && sh[12]) begin
            rdmode = 1'b1;
            sout = smem[sh[7:0]];
        end
    end
    always @(negedge ser_clk) begin
        if (rdmode && bc >= 13) begin
            ser_miso = sout[15];
            sout = {sout[14:0], 1'b0};
        end
    end
    always @(negedge ser_sel) begin
        if (!rdmode && bc == 29) begin
            smem[sh[23:16]] = sh[15:0];
            last_waddr = sh[27:16];
            wr_frames++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [15:0] a, output logic [31:0] v);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic wait_read(output logic [31:0] v);
        for (int k = 0; k < 1000; k++) begin
            hrd(16'h002C, v);
            if (!v[31]) break;
        end
    endtask

    task automatic drain();
        logic [31:0] s;
        for (int k = 0; k < 5000; k++) begin
            hrd(16'h0030, s);
            if (s[10]) break;
        end
        repeat (130) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [11:0] a12;
        logic [15:0] d16;
        int f0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 sel", 32'(ser_sel), 0);
        check("R1 sclk", 32'(ser_clk), 0);
        hrd(16'h002C, v); check("R1 result", v, 0);
        hrd(16'h0030, v); check("R1 status", v, 32'h400);

        // R2/R3: window write sweep
        for (int i = 0; i < 6; i++) begin
            a12 = 12'(i * 12'h2A3 + 12'h011);
            d16 = 16'hF00D ^ 16'(i * 16'h1357);
            hwr({4'h8, a12}, {16'hDEAD, d16});
            drain();
            check("R2 slave value", 32'(smem[a12[7:0]]), 32'(d16));
            check("R3 frame address", 32'(last_waddr), 32'(a12));
        end
        check("R3 sclk period", 32'(last_per), 32'(4 * CLK_PERIOD));

        // R4/R5: read sweep over written addresses plus an unwritten one
        for (int i = 0; i < 7; i++) begin
            a12 = (i < 6) ? 12'(i * 12'h2A3 + 12'h011) : 12'hABC;
            d16 = smem[a12[7:0]];
            hwr(16'h0028, 32'h1234_0000 | 32'(a12));
            hrd(16'h002C, v);
            check("R4 busy after command", 32'(v[31]), 1);
            wait_read(v);
            check("R5 result word", v, {4'b0, a12, d16});
        end

        // R6: second command while busy is ignored
        hwr(16'h0028, 32'h0AB);
        hwr(16'h0028, 32'h0CD);
        hrd(16'h0028, v); check("R6 command address held", v, 32'h0AB);
        wait_read(v);
        check("R6 result of first command", v, {4'b0, 12'h0AB, init_val(16'hAB)});

        // R7: read waits for queued writes
        hwr(16'h8033, 32'h1111);
        hwr(16'h8033, 32'h2222);
        hwr(16'h0028, 32'h033);
        wait_read(v);
        check("R7 read after writes", v, {4'b0, 12'h033, 16'h2222});

        // R8/R9: fill past capacity with back-to-back writes
        drain();
        f0 = wr_frames;
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            host_addr = 16'h8160 + 16'(i); host_wdata = 32'hA000 + 32'(i); host_wr = 1'b1;
            @(negedge clk);
        end
        host_wr = 1'b0;
        hrd(16'h0030, v);
        check("R8 R9 status full", v, 32'h1808);
        drain();
        check("R9 frames sent", 32'(wr_frames - f0), 9);
        for (int i = 0; i < 20; i++)
            check("R9 slave contents", 32'(smem[8'h60 + 8'(i)]),
                  (i < 9) ? 32'hA000 + 32'(i) : 32'(init_val(16'h60 + i)));
        hrd(16'h0030, v); check("R9 sticky after drain", v, 32'h1400);
        hwr(16'h0030, 32'h1000);
        hrd(16'h0030, v); check("R9 sticky cleared", v, 32'h0400);

        // R10: push in the cycle a full FIFO pops
        @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            host_addr = 16'h8180 + 16'(i); host_wdata = 32'hB000 + 32'(i); host_wr = 1'b1;
            @(negedge clk);
        end
        host_wr = 1'b0;
        hrd(16'h0030, v); check("R10 full before pop", v, 32'h0808);
        @(negedge ser_sel);
        @(negedge clk);
        check("R3 gap select low", 32'(ser_sel), 0);
        host_addr = 16'h8190; host_wdata = 32'hBEEF; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        check("R3 next frame after one cycle", 32'(ser_sel), 1);
        hrd(16'h0030, v); check("R10 accepted no overflow", v, 32'h0808);
        drain();
        check("R10 pushed value arrives", 32'(smem[8'h90]), 32'hBEEF);
        check("R10 last queued arrives", 32'(smem[8'h88]), 32'hB008);

        // R11: undefined offsets and out-of-window writes
        hrd(16'h0034, v); check("R11 undefined read", v, 0);
        hwr(16'h0034, 32'hFFFF_FFFF);
        hrd(16'h0034, v); check("R11 undefined after write", v, 0);
        hrd(16'h0030, v); check("R11 status unchanged", v, 32'h0400);
        hrd(16'h8010, v); check("R11 window read zero", v, 0);
        f0 = wr_frames;
        hwr(16'h9004, 32'h5555);
        hwr(16'h7FFC, 32'h6666);
        repeat (150) @(negedge clk);
        check("R11 no frame", 32'(wr_frames - f0), 0);
        check("R11 slave untouched", 32'(smem[8'h04]), 32'(init_val(4)));

        finished = 1;
        summary();
        $finish;
    end
endmodule